// File: doc/BRIEF.md
# Receive Address Filter Unit

This block sits on the receive path of an Ethernet MAC. Frame bytes arrive one per valid cycle, with a start marker on the first byte and an end marker on the last. The first six bytes are the destination address. The unit returns a pass or drop verdict for each frame on the cycle after the end marker. With the verdict it gives a 2-bit drop reason.

Four mechanisms decide the verdict, and each one has its own enable bit:
- exact matching against two stored unicast addresses;
- a 128-bit multicast hash table, indexed by seven bits of a CRC-32 computed over the destination bytes;
- an unconditional broadcast bypass;
- a minimum-length (runt) check.

Configuration is loaded through an 8-entry register write port. A zero control word disables every filter, so every frame passes.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, verdict_vld and verdict_code are 0. All configuration registers are zero, so the first frame passes.
- R2: verdict_vld pulses for exactly one cycle, on the cycle after the accepted end-marker byte. While it is low, verdict_pass and verdict_code are 0.
- R3: With the control register (address 0) written to zero, every frame passes with code 0, whatever its address or length.
- R4: Control bit 0 enables unicast matching. A non-multicast, non-broadcast destination then passes only if it equals stored address A or stored address B; otherwise the frame drops with code 1. The stored addresses are built as follows:
  - Register 1 holds the first two destination bytes, shared by both addresses: bits 15:8 hold byte 1 and bits 7:0 hold byte 2.
  - Registers 2 (address A) and 3 (address B) hold bytes 3 to 6 in bits 31:24 down to 7:0.
- R5: A frame is multicast when bit 0 of its first destination byte is 1. With control bit 1 clear, every multicast frame passes, even when unicast matching is on.
- R6: Control bit 1 enables hash filtering.
  - The hash index is bits 29:23 of a CRC-32 over the six destination bytes. The CRC uses the reflected polynomial 0xEDB88320 and starts from all ones. Bytes are taken in arrival order, each LSB first, and no final inversion is applied.
  - A multicast frame whose table bit is 0 drops with code 2.
- R7: The hash index selects a table word and a bit:
  - index / 32 selects one of the four table words at addresses 4 to 7;
  - index % 32 selects the bit within that word.
- R8: The all-ones destination passes the address filters whatever the unicast and hash settings are.
- R9: Control bit 2 enables the runt check, with the minimum length in control bits 15:8.
  - The frame length is the number of valid bytes from the start marker to the end marker, inclusive.
  - A frame shorter than the minimum drops with code 3.
  - A runt drop takes priority over any address miss.
  - Cycles with the valid input low inside a frame do not count toward the length.
- R10: Valid bytes outside a frame (after an end marker and before the next start marker) are ignored. They produce no verdict and do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (0 control, 1 shared octets, 2/3 address A/B, 4-7 hash words) |
| cfg_wdata | input | 32 | Register write data |
| rx_vld | input | 1 | Byte valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Frame byte |
| verdict_vld | output | 1 | Verdict strobe, one cycle after the end byte |
| verdict_pass | output | 1 | Frame accepted |
| verdict_code | output | 2 | Drop reason: 0 none, 1 unicast miss, 2 hash miss, 3 runt |

## Verification
The assertions are checked on every cycle. They cover three things:
- Idle outputs stay quiet between verdicts.
- Each drop code appears only when the matching enable bit was set at the end byte.
- A zero control word, or a broadcast frame without the runt check, always yields a pass.

The length counter is also checked: it stays nonzero inside a frame and holds still under stray bytes.

Some behaviour only the bench's scenarios can show, because it depends on the correct CRC bit selection, the octet layout of the stored addresses and the exact runt threshold. This covers:
- which hash word and bit a given multicast address lands on;
- that both unicast slots and the shared high octets compare correctly;
- that a length equal to the minimum passes while one byte less drops.

// File: rtl/afu_pkg.sv
package afu_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int HASH_WORDS = 4;
    localparam int HASH_IDX_W = 7;
    localparam int MINLEN_W   = 8;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_UNI_HI = 3'd1;
    localparam logic [2:0] REG_UNI_A  = 3'd2;
    localparam logic [2:0] REG_UNI_B  = 3'd3;
    localparam logic [2:0] REG_HASH0  = 3'd4;

    typedef enum logic [1:0] {
        DROP_NONE      = 2'd0,
        DROP_UNI_MISS  = 2'd1,
        DROP_HASH_MISS = 2'd2,
        DROP_RUNT      = 2'd3
    } drop_e;

    typedef struct packed {
        logic [MINLEN_W-1:0] min_len;
        logic                runt_en;
        logic                mc_en;
        logic                uni_en;
    } filt_ctrl_t;

    typedef logic [HASH_WORDS-1:0][31:0] hash_tbl_t;

    // One byte of a reflected CRC-32, LSB of the byte first
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/afu_frame_track.sv
module afu_frame_track
    import afu_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    output logic             eof_take,
    output logic [47:0]      dest_now,
    output logic [31:0]      crc_now,
    output logic [LEN_W-1:0] len_now
);

    logic             in_frame_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] base_len;
    logic [31:0]      crc_q;
    logic [31:0]      crc_base;
    logic             byte_take;
    logic [7:0]       dest_q    [ADDR_BYTES];
    logic [7:0]       dest_byte [ADDR_BYTES];

    assign byte_take = in_vld && (in_sof || in_frame_q);
    assign eof_take  = byte_take && in_eof;
    assign base_len  = in_sof ? '0 : len_q;
    assign len_now   = (&base_len) ? base_len : base_len + 1'b1;
    assign crc_base  = in_sof ? 32'hFFFF_FFFF : crc_q;
    assign crc_now   = (base_len < LEN_W'(ADDR_BYTES)) ? crc_byte(crc_base, in_data) : crc_base;

    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_dest
        assign dest_byte[i] = (byte_take && base_len == LEN_W'(i)) ? in_data
                            : (in_sof ? 8'h00 : dest_q[i]);
        assign dest_now[47-8*i -: 8] = dest_byte[i];

        always_ff @(posedge clk) begin
            if (rst)            dest_q[i] <= 8'h00;
            else if (byte_take) dest_q[i] <= dest_byte[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            len_q      <= '0;
            crc_q      <= 32'hFFFF_FFFF;
        end else if (byte_take) begin
            in_frame_q <= !in_eof;
            len_q      <= len_now;
            crc_q      <= crc_now;
        end
    end

    // R9
    len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        in_frame_q |-> (len_q != '0));

    // R10
    stray_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_frame_q && !in_sof) |=> $stable(len_q));

endmodule

// File: rtl/afu_cfg_regs.sv
module afu_cfg_regs
    import afu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output filt_ctrl_t  ctrl_q,
    output logic [15:0] uni_hi_q,
    output logic [31:0] uni_a_q,
    output logic [31:0] uni_b_q,
    output hash_tbl_t   hash_q
);

    logic unused_wdata;
    assign unused_wdata = ^{cfg_wdata[31:16], cfg_wdata[7:3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            uni_hi_q <= '0;
            uni_a_q  <= '0;
            uni_b_q  <= '0;
            hash_q   <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL: begin
                    ctrl_q.min_len <= cfg_wdata[15:8];
                    ctrl_q.runt_en <= cfg_wdata[2];
                    ctrl_q.mc_en   <= cfg_wdata[1];
                    ctrl_q.uni_en  <= cfg_wdata[0];
                end
                REG_UNI_HI: uni_hi_q <= cfg_wdata[15:0];
                REG_UNI_A:  uni_a_q  <= cfg_wdata;
                REG_UNI_B:  uni_b_q  <= cfg_wdata;
                default: begin
                    for (int w = 0; w < HASH_WORDS; w++) begin
                        if (cfg_addr == 3'(int'(REG_HASH0) + w)) hash_q[w] <= cfg_wdata;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/afu_verdict.sv
module afu_verdict
    import afu_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eof_take,
    input  filt_ctrl_t       ctrl,
    input  logic [15:0]      uni_hi,
    input  logic [31:0]      uni_a,
    input  logic [31:0]      uni_b,
    input  hash_tbl_t        hash_words,
    input  logic [47:0]      dest_now,
    input  logic [31:0]      crc_now,
    input  logic [LEN_W-1:0] len_now,
    output logic             vld_q,
    output logic             pass_q,
    output drop_e            code_q
);

    logic [HASH_IDX_W-1:0] hidx;
    logic  is_bcast, is_mc, hash_hit, uni_hit, is_runt;
    drop_e code_c;
    logic  unused_crc;

    assign unused_crc = ^{crc_now[31:30], crc_now[22:0]};
    assign hidx     = crc_now[29:23];
    assign is_bcast = &dest_now;
    assign is_mc    = dest_now[40];
    assign hash_hit = hash_words[hidx[6:5]][hidx[4:0]];
    assign uni_hit  = (dest_now == {uni_hi, uni_a}) || (dest_now == {uni_hi, uni_b});
    assign is_runt  = ctrl.runt_en && (len_now < LEN_W'(ctrl.min_len));

    always_comb begin
        if (is_runt)       code_c = DROP_RUNT;
        else if (is_bcast) code_c = DROP_NONE;
        else if (is_mc)    code_c = (ctrl.mc_en && !hash_hit) ? DROP_HASH_MISS : DROP_NONE;
        else               code_c = (ctrl.uni_en && !uni_hit) ? DROP_UNI_MISS : DROP_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            pass_q <= 1'b0;
            code_q <= DROP_NONE;
        end else begin
            vld_q  <= eof_take;
            pass_q <= eof_take && (code_c == DROP_NONE);
            code_q <= eof_take ? code_c : DROP_NONE;
        end
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_q |-> (!pass_q && code_q == DROP_NONE));

    // R3
    all_off_pass_chk: assert property (@(posedge clk) disable iff (rst)
        $past(eof_take && !rst && ctrl == '0) |-> (vld_q && pass_q));

    // R4
    uni_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && code_q == DROP_UNI_MISS) |-> $past(ctrl.uni_en));

    // R6
    hash_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && code_q == DROP_HASH_MISS) |-> $past(ctrl.mc_en));

    // R9
    runt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && code_q == DROP_RUNT) |-> $past(ctrl.runt_en));

    // R8
    bcast_pass_chk: assert property (@(posedge clk) disable iff (rst)
        $past(eof_take && !rst && (&dest_now) && !ctrl.runt_en) |-> pass_q);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import afu_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        rx_vld,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    output logic        verdict_vld,
    output logic        verdict_pass,
    output logic [1:0]  verdict_code
);

    logic             eof_take;
    logic [47:0]      dest_now;
    logic [31:0]      crc_now;
    logic [LEN_W-1:0] len_now;
    filt_ctrl_t       ctrl_q;
    logic [15:0]      uni_hi_q;
    logic [31:0]      uni_a_q, uni_b_q;
    hash_tbl_t        hash_q;
    drop_e            code_q;

    afu_frame_track #(.LEN_W(LEN_W)) trk_i (
        .clk(clk), .rst(rst),
        .in_vld(rx_vld), .in_sof(rx_sof), .in_eof(rx_eof), .in_data(rx_data),
        .eof_take(eof_take), .dest_now(dest_now), .crc_now(crc_now), .len_now(len_now)
    );

    afu_cfg_regs regs_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ctrl_q(ctrl_q), .uni_hi_q(uni_hi_q), .uni_a_q(uni_a_q), .uni_b_q(uni_b_q),
        .hash_q(hash_q)
    );

    afu_verdict #(.LEN_W(LEN_W)) vrd_i (
        .clk(clk), .rst(rst),
        .eof_take(eof_take), .ctrl(ctrl_q),
        .uni_hi(uni_hi_q), .uni_a(uni_a_q), .uni_b(uni_b_q), .hash_words(hash_q),
        .dest_now(dest_now), .crc_now(crc_now), .len_now(len_now),
        .vld_q(verdict_vld), .pass_q(verdict_pass), .code_q(code_q)
    );

    assign verdict_code = code_q;

endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        rx_vld, rx_sof, rx_eof;
    logic [7:0]  rx_data;
    logic        verdict_vld, verdict_pass;
    logic [1:0]  verdict_code;

    int n_chk  = 0;
    int n_fail = 0;

    logic        sh_uni, sh_mc, sh_runt;
    logic [7:0]  sh_min;
    logic [15:0] sh_hi;
    logic [31:0] sh_a, sh_b;
    logic [31:0] sh_hash [4];

    always #4ns clk = ~clk;

    rx_addr_filter dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .verdict_vld(verdict_vld), .verdict_pass(verdict_pass), .verdict_code(verdict_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bench_crc(input logic [47:0] d);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ d[40 - 8*k + b];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return c;
    endfunction

    function automatic int hash_idx(input logic [47:0] d);
        logic [31:0] c;
        c = bench_crc(d);
        return int'(c[29:23]);
    endfunction

    function automatic int exp_code(input logic [47:0] d, input int len);
        int idx;
        idx = hash_idx(d);
        if (sh_runt && len < int'(sh_min)) return 3;
        if (d == 48'hFFFF_FFFF_FFFF) return 0;
        if (d[40]) return (sh_mc && !sh_hash[idx/32][idx%32]) ? 2 : 0;
        if (sh_uni && d != {sh_hi, sh_a} && d != {sh_hi, sh_b}) return 1;
        return 0;
    endfunction

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (addr)
            0: begin sh_uni = data[0]; sh_mc = data[1]; sh_runt = data[2]; sh_min = data[15:8]; end
            1: sh_hi = data[15:0];
            2: sh_a = data;
            3: sh_b = data;
            default: sh_hash[addr-4] = data;
        endcase
    endtask

    task automatic idle_in();
        rx_vld = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h00;
    endtask

    // Sends a frame, then checks the verdict strobe, code, pass and the strobe's end
    task automatic run_frame(input string req, input logic [47:0] d, input int len, input bit gap);
        int e;
        e = exp_code(d, len);
        for (int i = 0; i < len; i++) begin
            if (gap && (i == 3 || i == len - 2)) begin
                @(negedge clk);
                idle_in();
            end
            @(negedge clk);
            rx_vld = 1'b1;
            rx_sof = (i == 0);
            rx_eof = (i == len - 1);
            rx_data = (i < 6) ? d[47 - 8*i -: 8] : 8'(i * 7);
        end
        @(negedge clk);
        idle_in();
        chk({req, " verdict strobe"}, int'(verdict_vld), 1);
        chk({req, " drop code"}, int'(verdict_code), e);
        chk({req, " pass flag"}, int'(verdict_pass), int'(e == 0));
        @(negedge clk);
        chk("R2 strobe single cycle", int'(verdict_vld), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        idle_in();
        sh_uni = 0; sh_mc = 0; sh_runt = 0; sh_min = 0; sh_hi = 0; sh_a = 0; sh_b = 0;
        for (int w = 0; w < 4; w++) sh_hash[w] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset verdict_vld", int'(verdict_vld), 0);
        chk("R1 reset verdict_code", int'(verdict_code), 0);
        run_frame("R1 first frame after reset", 48'h1234_5678_9ABC, 20, 0);
    endtask

    task automatic t_all_off();
        wr(0, 32'h0000_4007);
        wr(0, 32'h0);
        run_frame("R3 unicast all off", 48'h0202_0304_0506, 30, 0);
        run_frame("R3 multicast all off", 48'h0100_5E11_2233, 64, 1);
        run_frame("R3 short frame all off", 48'h0A0B_0C0D_0E0F, 8, 0);
    endtask

    task automatic t_unicast();
        wr(1, 32'h0000_0A1B);
        wr(2, 32'h2C3D_4E5F);
        wr(3, 32'h6677_8899);
        wr(0, 32'h0000_0001);
        run_frame("R4 match slot A", 48'h0A1B_2C3D_4E5F, 40, 0);
        run_frame("R4 match slot B", 48'h0A1B_6677_8899, 40, 1);
        run_frame("R4 low octet miss", 48'h0A1B_2C3D_4E5E, 40, 0);
        run_frame("R4 shared octet miss", 48'h0A1C_6677_8899, 40, 0);
        run_frame("R5 multicast with hash off", 48'h0300_0000_0001, 40, 0);
    endtask

    task automatic t_hash();
        logic [47:0] pick [4];
        bit          got  [4];
        for (int q = 0; q < 4; q++) got[q] = 0;
        for (int k = 0; k < 256; k++) begin
            logic [47:0] d;
            int          q;
            d = {24'h01005E, 16'h0000, 8'(k)};
            q = hash_idx(d) / 32;
            if (!got[q]) begin got[q] = 1; pick[q] = d; end
        end
        wr(0, 32'h0000_0003);
        for (int w = 0; w < 4; w++) wr(4 + w, 32'h0);
        run_frame("R6 empty table drop", 48'h0100_5E00_0042, 40, 0);
        for (int q = 0; q < 4; q++) begin
            if (got[q]) begin
                int idx;
                idx = hash_idx(pick[q]);
                wr(4 + q, 32'h1 << (idx % 32));
                run_frame("R7 bit in selected word", pick[q], 40, 0);
                wr(4 + q, 32'h0);
                wr(4 + (q + 1) % 4, 32'h1 << (idx % 32));
                run_frame("R7 bit in wrong word", pick[q], 40, 0);
                wr(4 + (q + 1) % 4, 32'h0);
            end
        end
        wr(4, 32'hFFFF_FFFF);
        run_frame("R6 mixed table", 48'h0100_5E7F_0001, 40, 1);
        wr(4, 32'h0);
    endtask

    task automatic t_bcast();
        wr(0, 32'h0000_0003);
        run_frame("R8 broadcast passes filters", 48'hFFFF_FFFF_FFFF, 40, 0);
        wr(0, 32'h0000_4007);
        run_frame("R9 runt beats broadcast", 48'hFFFF_FFFF_FFFF, 20, 0);
    endtask

    task automatic t_runt();
        wr(0, 32'h0000_4004);
        run_frame("R9 one below minimum", 48'h0A1B_2C3D_4E5F, 63, 0);
        run_frame("R9 exactly minimum", 48'h0A1B_2C3D_4E5F, 64, 0);
        run_frame("R9 above minimum", 48'h1111_2222_3333, 65, 0);
        run_frame("R9 gaps not counted", 48'h1111_2222_3333, 63, 1);
        run_frame("R9 tiny frame", 48'h1111_2222_3333, 3, 0);
        wr(0, 32'h0000_4005);
        run_frame("R9 runt over unicast miss", 48'h1111_2222_3333, 20, 0);
        run_frame("R4 long unicast miss", 48'h1111_2222_3333, 70, 0);
    endtask

    task automatic t_stray();
        int seen;
        wr(0, 32'h0000_4005);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (verdict_vld) seen++;
            rx_vld = 1'b1; rx_sof = 1'b0; rx_eof = (i == 2 || i == 5); rx_data = 8'hFF;
        end
        @(negedge clk);
        if (verdict_vld) seen++;
        idle_in();
        @(negedge clk);
        if (verdict_vld) seen++;
        chk("R10 stray bytes give no verdict", seen, 0);
        run_frame("R10 frame after stray bytes", 48'h0A1B_6677_8899, 64, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_all_off();
        t_unicast();
        t_hash();
        t_bcast();
        t_runt();
        t_stray();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule